// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry Controller

This block carries out the software-driven steps that put an SDRAM into self-refresh and take it out again. Software reaches it through a small write port with two registers. The control register holds an enable bit and a mode bit. Self-refresh is requested only when both bits are 1. The command register holds a two-bit field that issues a single precharge-all or auto-refresh command on an abstract command bus. The field then clears itself.

A request is held off until four conditions are met. No memory transaction may be in flight. No auto-refresh may be running. Since the last entry or reset, a precharge-all must have been issued, followed by an auto-refresh. When the request is held off, a pending flag is shown. Once the block is in self-refresh it drives clock-enable low and stays there. CPU sleep and wake events do not change this. Only clearing the request ends it. On exit, clock-enable rises, and the block reports ready again after a fixed number of recovery cycles set by `EXIT_CYC`.

Top module: `srf_entry_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `cke`=1, `sts_ready`=1, `cmd_valid`=0, `cmd_code`=0, `cmd_field`=0, and `sts_pending`, `sts_in_sr`, `sts_err` and `sts_sleep_hold` are all 0.
- R2: A write to address 1 with data 1 (precharge-all) or 2 (auto-refresh) is accepted when all of these hold: the block is ready, the field is 0, and no entry happens in the same cycle. `cmd_field` then shows the code in the next cycle. One cycle later `cmd_valid` pulses for one cycle with `cmd_code` equal to the same value (1 = precharge-all, 2 = auto-refresh), and in that cycle `cmd_field` returns to 0.
- R3: Writing field code 0 or 3 issues no command and leaves `cmd_field` at 0.
- R4: Entry requires a precharge-all followed by an auto-refresh since the last entry or reset. A precharge-all issued after the auto-refresh cancels the auto-refresh. While either step is missing, no entry occurs.
- R5: While `txn_busy` or `ar_busy` is 1, entry is held off. `sts_pending` is 1 whenever a request is set and `sts_ready` is 1.
- R6: When a request is set and all entry conditions hold, the next clock edge enters self-refresh. `cmd_valid` pulses with `cmd_code`=3, `cke` goes to 0, `sts_in_sr` goes to 1, and `sts_ready` and `sts_pending` go to 0.
- R7: A write to address 0 sets the enable bit from data bit 0 and the mode bit from data bit 1. A request exists only when both bits are 1.
- R8: `cpu_sleep` and `cpu_wake` do not change `cke` or `sts_in_sr`. `sts_sleep_hold` goes to 1 the cycle after `cpu_sleep` is seen in self-refresh. It is cleared by `cpu_wake` or by leaving self-refresh.
- R9: One cycle after the request drops in self-refresh, `cmd_valid` pulses with `cmd_code`=4, `cke` goes to 1 and `sts_in_sr` goes to 0. `sts_ready` returns to 1 exactly `EXIT_CYC` cycles after `cke` rises.
- R10: A field write of code 1 or 2 while `sts_ready` is 0 is ignored: no command is issued and `cmd_field` stays 0. `sts_err` goes to 1 the cycle after that write and stays 1 until reset.
- R11: Entering self-refresh clears the preparation history, so the next entry again needs a new precharge-all and auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control (enable, mode), 1 = command field |
| cfg_wdata | input | 2 | Write data |
| txn_busy | input | 1 | Memory transactions outstanding |
| ar_busy | input | 1 | Auto-refresh in progress |
| cpu_sleep | input | 1 | CPU entering sleep |
| cpu_wake | input | 1 | CPU woken by interrupt |
| cmd_valid | output | 1 | Command bus strobe |
| cmd_code | output | 3 | 0 none, 1 precharge-all, 2 auto-refresh, 3 self-refresh entry, 4 self-refresh exit |
| cke | output | 1 | Memory clock-enable |
| cmd_field | output | 2 | Readback of the command field |
| sts_pending | output | 1 | Request waiting on entry conditions |
| sts_in_sr | output | 1 | Memory held in self-refresh |
| sts_ready | output | 1 | Controller idle and ready |
| sts_err | output | 1 | Sticky: command written while not ready |
| sts_sleep_hold | output | 1 | CPU asleep while in self-refresh |

## Verification
Each result has a fixed latency, and the checks sample at exactly that point:
- A field write appears in `cmd_field` one cycle later, and its bus pulse comes one cycle after that.
- Entry follows the cycle in which the last condition becomes true by one edge, and so does exit after the request drops.
- Ready returns `EXIT_CYC` cycles after clock-enable rises.

The bench drives inputs on the falling clock edge and reads outputs on the next falling edge. It counts edges to the exact cycle each latency predicts. It also checks that nothing changes during the hold-off cycles, during the sleep and wake events, and in the single cycle before ready would be early.

// File: rtl/srf_pkg.sv
// Package: shared codes for the self-refresh entry controller.
// Assumes a two-bit software command field and a three-bit command bus.
package srf_pkg;

    typedef enum logic [2:0] {
        BUS_NOP    = 3'd0,
        BUS_PREALL = 3'd1,
        BUS_REFA   = 3'd2,
        BUS_SRE    = 3'd3,
        BUS_SRX    = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FLD_NONE   = 2'd0,
        FLD_PREALL = 2'd1,
        FLD_REFA   = 2'd2,
        FLD_RSVD   = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_SELF  = 2'd1,
        ST_WAKE  = 2'd2
    } hold_st_e;

    localparam logic CFG_ADDR_CTRL = 1'b0;
    localparam logic CFG_ADDR_CMD  = 1'b1;

endpackage

// File: rtl/srf_cmd_field.sv
// Module: software command field.
// It holds a one-shot precharge-all or auto-refresh request until that
// request goes out on the bus, then clears to none. A write arriving while
// the controller is not ready is dropped and sets a sticky error.
// Assumes the top registers the bus, so issue_o is combinational.
module srf_cmd_field
    import srf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  logic [1:0] wdata_i,
    input  logic     ready_i,
    input  logic     enter_i,
    output fld_e     field_o,
    output logic     issue_o,
    output bus_cmd_e issue_code_o,
    output logic     err_o
);
    fld_e field_q;
    logic err_q;
    logic is_cmd;
    logic accept_ok;

    // Decode whether the write carries a real command and can be taken now.
    always_comb begin
        is_cmd    = (wdata_i == FLD_PREALL) || (wdata_i == FLD_REFA);
        accept_ok = ready_i && !enter_i && (field_q == FLD_NONE);
    end

    // Capture, self-clear and error tracking for the command field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= FLD_NONE;
            err_q   <= 1'b0;
        end else begin
            if (field_q != FLD_NONE) begin
                field_q <= FLD_NONE;
            end else if (wr_i && is_cmd && accept_ok) begin
                field_q <= fld_e'(wdata_i);
            end
            if (wr_i && is_cmd && !ready_i) begin
                err_q <= 1'b1;
            end
        end
    end

    // Map the held field code onto the bus command.
    always_comb begin
        issue_o      = (field_q != FLD_NONE);
        issue_code_o = BUS_NOP;
        if (field_q == FLD_PREALL) begin
            issue_code_o = BUS_PREALL;
        end else if (field_q == FLD_REFA) begin
            issue_code_o = BUS_REFA;
        end
    end

    assign field_o = field_q;
    assign err_o   = err_q;

endmodule

// File: rtl/srf_guard.sv
// Module: entry guard.
// It holds the enable and mode bits and tracks the precharge-all then
// auto-refresh preparation. From these it decides when entry may proceed.
// Assumes issue_i pulses exactly in the cycle a field command goes out.
module srf_guard
    import srf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  logic [1:0] wdata_i,
    input  logic     issue_i,
    input  bus_cmd_e issue_code_i,
    input  logic     txn_busy_i,
    input  logic     ar_busy_i,
    input  logic     field_idle_i,
    input  logic     ready_i,
    output logic     req_o,
    output logic     enter_o,
    output logic     pending_o
);
    logic en_q;
    logic mode_q;
    logic pa_done_q;
    logic ra_done_q;

    // Control register: enable bit from data bit 0, mode bit from bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
        end else if (wr_i) begin
            en_q   <= wdata_i[0];
            mode_q <= wdata_i[1];
        end
    end

    // Preparation history: precharge-all, then auto-refresh, cleared on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_done_q <= 1'b0;
            ra_done_q <= 1'b0;
        end else if (enter_o) begin
            pa_done_q <= 1'b0;
            ra_done_q <= 1'b0;
        end else if (issue_i && issue_code_i == BUS_PREALL) begin
            pa_done_q <= 1'b1;
            ra_done_q <= 1'b0;
        end else if (issue_i && issue_code_i == BUS_REFA && pa_done_q) begin
            ra_done_q <= 1'b1;
        end
    end

    // Request, entry permission and pending status.
    always_comb begin
        req_o     = en_q && mode_q;
        enter_o   = req_o && ready_i && !txn_busy_i && !ar_busy_i
                    && ra_done_q && field_idle_i;
        pending_o = req_o && ready_i;
    end

endmodule

// File: rtl/srf_hold_fsm.sv
// Module: self-refresh hold state machine.
// It stays in self-refresh until the request drops, whatever the CPU sleep
// and wake inputs do. After exit it counts EXIT_CYC recovery cycles.
// Assumes EXIT_CYC >= 1 and that enter_i is only raised when ready.
module srf_hold_fsm
    import srf_pkg::*;
#(
    parameter int EXIT_CYC = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enter_i,
    input  logic     req_i,
    input  logic     cpu_sleep_i,
    input  logic     cpu_wake_i,
    output logic     ready_o,
    output logic     in_sr_o,
    output logic     cke_o,
    output logic     bus_v_o,
    output bus_cmd_e bus_code_o,
    output logic     sleep_hold_o
);
    localparam int CNT_W = (EXIT_CYC < 2) ? 1 : $clog2(EXIT_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXIT_CYC - 1);

    hold_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cke_q;
    logic             slp_q;
    logic             go_srx;

    // Exit is requested when software drops the request while held.
    assign go_srx = (st_q == ST_SELF) && !req_i;

    // State, recovery counter and clock-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_READY;
            cnt_q <= '0;
            cke_q <= 1'b1;
        end else begin
            case (st_q)
                ST_READY: if (enter_i) begin
                    st_q  <= ST_SELF;
                    cke_q <= 1'b0;
                end
                ST_SELF: if (go_srx) begin
                    st_q  <= ST_WAKE;
                    cke_q <= 1'b1;
                    cnt_q <= '0;
                end
                ST_WAKE: begin
                    if (cnt_q == CNT_LAST) begin
                        st_q <= ST_READY;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_READY;
            endcase
        end
    end

    // Sleep-while-held flag, cleared by wake or by leaving self-refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slp_q <= 1'b0;
        end else if (cpu_wake_i || st_q != ST_SELF) begin
            slp_q <= 1'b0;
        end else if (cpu_sleep_i) begin
            slp_q <= 1'b1;
        end
    end

    // Bus requests raised on the transitions.
    always_comb begin
        bus_v_o    = 1'b0;
        bus_code_o = BUS_NOP;
        if (st_q == ST_READY && enter_i) begin
            bus_v_o    = 1'b1;
            bus_code_o = BUS_SRE;
        end else if (go_srx) begin
            bus_v_o    = 1'b1;
            bus_code_o = BUS_SRX;
        end
    end

    assign ready_o      = (st_q == ST_READY);
    assign in_sr_o      = (st_q == ST_SELF);
    assign cke_o        = cke_q;
    assign sleep_hold_o = slp_q;

endmodule

// File: rtl/srf_entry_ctrl.sv
// Module: SDRAM self-refresh entry controller, top level.
// It joins the command field, the entry guard and the hold FSM, and
// registers the shared command bus. Field commands and state-machine
// commands never coincide, because the guard needs an idle field to enter
// and the field rejects writes while not ready.
module srf_entry_ctrl
    import srf_pkg::*;
#(
    parameter int EXIT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [1:0] cfg_wdata,
    input  logic       txn_busy,
    input  logic       ar_busy,
    input  logic       cpu_sleep,
    input  logic       cpu_wake,
    output logic       cmd_valid,
    output logic [2:0] cmd_code,
    output logic       cke,
    output logic [1:0] cmd_field,
    output logic       sts_pending,
    output logic       sts_in_sr,
    output logic       sts_ready,
    output logic       sts_err,
    output logic       sts_sleep_hold
);
    logic     wr_ctrl, wr_cmd;
    fld_e     field;
    logic     fld_issue;
    bus_cmd_e fld_code;
    logic     req, enter, ready;
    logic     fsm_v;
    bus_cmd_e fsm_code;
    bus_cmd_e bus_q;
    logic     bus_v_q;

    // Address decode of the register write port.
    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == CFG_ADDR_CTRL);
        wr_cmd  = cfg_we && (cfg_addr == CFG_ADDR_CMD);
    end

    srf_cmd_field u_field (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_cmd),
        .wdata_i      (cfg_wdata),
        .ready_i      (ready),
        .enter_i      (enter),
        .field_o      (field),
        .issue_o      (fld_issue),
        .issue_code_o (fld_code),
        .err_o        (sts_err)
    );

    srf_guard u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_ctrl),
        .wdata_i      (cfg_wdata),
        .issue_i      (fld_issue),
        .issue_code_i (fld_code),
        .txn_busy_i   (txn_busy),
        .ar_busy_i    (ar_busy),
        .field_idle_i (field == FLD_NONE),
        .ready_i      (ready),
        .req_o        (req),
        .enter_o      (enter),
        .pending_o    (sts_pending)
    );

    srf_hold_fsm #(.EXIT_CYC(EXIT_CYC)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_i      (enter),
        .req_i        (req),
        .cpu_sleep_i  (cpu_sleep),
        .cpu_wake_i   (cpu_wake),
        .ready_o      (ready),
        .in_sr_o      (sts_in_sr),
        .cke_o        (cke),
        .bus_v_o      (fsm_v),
        .bus_code_o   (fsm_code),
        .sleep_hold_o (sts_sleep_hold)
    );

    // Register the command bus from whichever source is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_v_q <= 1'b0;
            bus_q   <= BUS_NOP;
        end else if (fld_issue) begin
            bus_v_q <= 1'b1;
            bus_q   <= fld_code;
        end else if (fsm_v) begin
            bus_v_q <= 1'b1;
            bus_q   <= fsm_code;
        end else begin
            bus_v_q <= 1'b0;
            bus_q   <= BUS_NOP;
        end
    end

    assign cmd_valid = bus_v_q;
    assign cmd_code  = bus_q;
    assign cmd_field = field;
    assign sts_ready = ready;

endmodule

// File: rtl/srf_entry_ctrl_chk.sv
// Checker: temporal properties of the self-refresh entry controller,
// bound to the top. Assumes the request net of the top is visible.
module srf_entry_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic [1:0] cmd_field,
    input logic       sts_in_sr,
    input logic       sts_ready,
    input logic       sts_err,
    input logic       txn_busy,
    input logic       ar_busy,
    input logic       req
);
    AST_CKE_LOW_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        sts_in_sr |-> !cke); // R6
    AST_SRE_WITH_CKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd_valid && cmd_code == 3'd3)); // R6
    AST_ENTRY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!txn_busy && !ar_busy)); // R5
    AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_in_sr && req) |=> sts_in_sr); // R8
    AST_FIELD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_field != 2'd0) |=> (cmd_field == 2'd0)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts_err |=> sts_err); // R10
    AST_READY_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ready |-> cke); // R9
    AST_NO_FIELD_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        sts_in_sr |-> (cmd_field == 2'd0)); // R10
endmodule

bind srf_entry_ctrl srf_entry_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_field (cmd_field),
    .sts_in_sr (sts_in_sr),
    .sts_ready (sts_ready),
    .sts_err   (sts_err),
    .txn_busy  (txn_busy),
    .ar_busy   (ar_busy),
    .req       (req)
);

// File: tb/srf_entry_ctrl_bench.sv
// Bench: self-checking sweep of the self-refresh entry controller with a
// short recovery window. Inputs change on falling edges and outputs are
// read on falling edges.
module srf_entry_ctrl_bench;
    localparam int EXIT_CYC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [1:0] cfg_wdata = 2'd0;
    logic       txn_busy = 1'b0;
    logic       ar_busy = 1'b0;
    logic       cpu_sleep = 1'b0;
    logic       cpu_wake = 1'b0;
    logic       cmd_valid;
    logic [2:0] cmd_code;
    logic       cke;
    logic [1:0] cmd_field;
    logic       sts_pending, sts_in_sr, sts_ready, sts_err, sts_sleep_hold;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    srf_entry_ctrl #(.EXIT_CYC(EXIT_CYC)) u_srf_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .txn_busy(txn_busy), .ar_busy(ar_busy),
        .cpu_sleep(cpu_sleep), .cpu_wake(cpu_wake), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cke(cke), .cmd_field(cmd_field),
        .sts_pending(sts_pending), .sts_in_sr(sts_in_sr),
        .sts_ready(sts_ready), .sts_err(sts_err),
        .sts_sleep_hold(sts_sleep_hold)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    // Issue a field command: write, then wait through the bus pulse cycle.
    task automatic issue(input logic [1:0] c);
        wr(1'b1, c);
        step();
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 cke", cke, 1);
        chk("R1 ready", sts_ready, 1);
        chk("R1 valid", cmd_valid, 0);
        chk("R1 code", cmd_code, 0);
        chk("R1 field", cmd_field, 0);
        chk("R1 pending", sts_pending, 0);
        chk("R1 in_sr", sts_in_sr, 0);
        chk("R1 err", sts_err, 0);
        chk("R1 sleep_hold", sts_sleep_hold, 0);

        // R7 sweep of the control bits with no preparation: no entry
        for (int v = 0; v < 4; v++) begin
            wr(1'b0, 2'(v));
            chk("R7 pending", sts_pending, (v == 3) ? 1 : 0);
            step();
            chk("R7 cke", cke, 1);
            chk("R4 no entry", sts_in_sr, 0);
        end
        wr(1'b0, 2'd0);

        // R2 and R3 sweep of the field codes
        for (int c = 0; c < 4; c++) begin
            int real_cmd;
            real_cmd = (c == 1 || c == 2) ? 1 : 0;
            wr(1'b1, 2'(c));
            chk(real_cmd ? "R2 field" : "R3 field", cmd_field, real_cmd ? c : 0);
            step();
            chk(real_cmd ? "R2 valid" : "R3 valid", cmd_valid, real_cmd);
            chk(real_cmd ? "R2 code" : "R3 code", cmd_code, real_cmd ? c : 0);
            chk("R2 self clear", cmd_field, 0);
            step();
            chk("R2 one pulse", cmd_valid, 0);
        end

        // R4 a precharge-all after the auto-refresh invalidates it
        issue(2'd1);
        wr(1'b0, 2'd3);
        repeat (3) begin
            step();
            chk("R4 held", cke, 1);
            chk("R5 pending", sts_pending, 1);
        end

        // R5 hold-off by transaction busy, then auto-refresh busy
        txn_busy = 1'b1;
        issue(2'd2);
        repeat (3) begin
            step();
            chk("R5 txn hold", cke, 1);
            chk("R5 pending txn", sts_pending, 1);
        end
        ar_busy = 1'b1;
        txn_busy = 1'b0;
        repeat (3) begin
            step();
            chk("R5 ar hold", cke, 1);
        end
        ar_busy = 1'b0;
        step();
        // R6 entry one edge after the last condition clears
        chk("R6 cke", cke, 0);
        chk("R6 valid", cmd_valid, 1);
        chk("R6 code", cmd_code, 3);
        chk("R6 in_sr", sts_in_sr, 1);
        chk("R6 ready", sts_ready, 0);
        chk("R6 pending", sts_pending, 0);

        // R8 sleep and wake leave the hold untouched
        cpu_sleep = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R8 sleep_hold", sts_sleep_hold, 1);
            chk("R8 cke", cke, 0);
            chk("R8 in_sr", sts_in_sr, 1);
        end
        cpu_sleep = 1'b0;
        cpu_wake = 1'b1;
        step();
        cpu_wake = 1'b0;
        chk("R8 wake clears", sts_sleep_hold, 0);
        step();
        chk("R8 cke after wake", cke, 0);
        chk("R8 in_sr after wake", sts_in_sr, 1);

        // R10 command written while held is dropped and flagged
        wr(1'b1, 2'd1);
        chk("R10 err", sts_err, 1);
        chk("R10 field", cmd_field, 0);
        step();
        chk("R10 no cmd", cmd_valid, 0);
        chk("R10 still held", sts_in_sr, 1);

        // R7 clearing one bit drops the request; R9 exit and recovery
        wr(1'b0, 2'd1);
        chk("R9 not yet", cke, 0);
        step();
        chk("R9 cke", cke, 1);
        chk("R9 valid", cmd_valid, 1);
        chk("R9 code", cmd_code, 4);
        chk("R9 in_sr", sts_in_sr, 0);
        for (int i = 1; i < EXIT_CYC; i++) begin
            step();
            chk("R9 recovering", sts_ready, 0);
        end
        step();
        chk("R9 ready", sts_ready, 1);

        // R11 a fresh entry needs new preparation
        wr(1'b0, 2'd3);
        issue(2'd2);
        repeat (2) begin
            step();
            chk("R11 no entry", cke, 1);
        end
        issue(2'd1);
        chk("R11 still out", cke, 1);
        issue(2'd2);
        chk("R11 entered", cke, 0);
        chk("R11 code", cmd_code, 3);
        chk("R10 err sticky", sts_err, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule